// File: doc/BRIEF.md
# Channel-Strided Sample Readback Engine

This engine returns recorded samples to a host from a circular sample memory. In that memory, every scan writes all active channels back to back. The host starts an unload by naming a channel and a scan offset. The offset is counted from the oldest scan still held in memory.

Once the request is accepted, the engine points the memory address at that channel's sample in the chosen scan and prefetches the word into a holding register. Each later read strobe does three things:

- It answers with the held sample, widened to 16 bits with its sign extended.
- It steps the address forward by a stride that the strobe's sub-address selects. The step is the active channel count times (sub-address + 1), wrapped to the memory depth.
- It fetches the next word.

A request for a channel that was not recorded since the last arm is refused. A read made while no unload is active returns zero.

Top module: `unl_engine`

## Requirements
- R1: After reset, `rd_data` is 0, `q` is 0 and `mem_addr` is 0, and the engine is outside unload mode.
- R2: An accepted request sets `mem_addr` to ((`oldest_scan` + `req_offset`) × N + `req_chan`) mod 2^ADDR_W one cycle later. N is the active channel count, taken from `act_code` as 0→4, 1→8, 2→16, 3→32.
- R3: A request whose channel is not below N, or made while `data_present` is low, drives `q` to 0 one cycle later and leaves the engine outside unload mode.
- R4: A read strobe made outside unload mode drives `rd_data` and `q` to 0 one cycle later and leaves `mem_addr` unchanged.
- R5: A returned sample is the 12-bit memory word placed in bits 11:0, with bits 15:12 copying bit 11.
- R6: Each read in unload mode returns the word stored at the address that was current before the read, and sets `q` to 1. The word at the new address is captured three cycles after the strobe, so the host leaves at least three cycles between strobes.
- R7: A read in unload mode with `rd_sub` = s advances `mem_addr` by (s + 1) × N, modulo 2^ADDR_W.
- R8: An `arm` pulse ends unload mode, so a later read returns 0 with `q` = 0.
- R9: When `arm` and `rd_stb` come in the same cycle, the read returns 0 with `q` = 0. When `req_valid` and `rd_stb` come in the same cycle, the request is handled and the read is dropped, leaving `rd_data` unchanged.
- R10: An accepted request drives `q` to 1 one cycle later and enters unload mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | New acquisition armed; ends unload mode |
| req_valid | input | 1 | Unload request strobe |
| req_chan | input | 5 | Requested channel, 0 to 31 |
| req_offset | input | 8 | Scans to skip past the oldest scan |
| act_code | input | 2 | Active channel count code (4/8/16/32) |
| oldest_scan | input | ADDR_W | Index of the oldest scan held in memory |
| data_present | input | 1 | At least one scan recorded since arm |
| rd_stb | input | 1 | Read strobe |
| rd_sub | input | 4 | Stride select: every (rd_sub+1)-th sample |
| mem_addr | output | ADDR_W | Sample memory address |
| mem_rdata | input | 12 | Memory word, one cycle after the address |
| rd_data | output | 16 | Sign-extended sample returned to the host |
| q | output | 1 | Response flag of the last command |

## Verification
Two events can land on the same edge: a read strobe together with an `arm` pulse, and a read strobe together with a new unload request. The bench drives each pair from a single negative edge while a valid unload is active, so the read alone would return data. For `arm`, it then expects a zero word with `q` low and a read refused afterwards. For a request, it expects `q` to reflect the request, the address to move to the new start, and `rd_data` to keep its earlier value.

// File: rtl/unl_pkg.sv
package unl_pkg;
    localparam int SAMP_W = 12;
    localparam int OUT_W  = 16;
    localparam int CHAN_W = 5;
    localparam int OFF_W  = 8;
    localparam int CODE_W = 2;
    localparam int SUB_W  = 4;
endpackage

// File: rtl/unl_addr.sv
module unl_addr
    import unl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [CODE_W-1:0] act_code,
    input  logic [CHAN_W-1:0] chan,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] oldest,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SUB_W-1:0]  sub,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              chan_ok
);
    localparam int CNT_W = CHAN_W + 1;
    localparam int SH_W  = CODE_W + 1;

    logic [SH_W-1:0]   shift;
    logic [CNT_W-1:0]  n_active;
    logic [ADDR_W-1:0] scan_idx;
    logic [ADDR_W-1:0] stride;

    always_comb begin
        shift      = {1'b0, act_code} + SH_W'(2);
        n_active   = CNT_W'(4) << act_code;
        chan_ok    = {1'b0, chan} < n_active;
        scan_idx   = oldest + ADDR_W'(offset);
        start_addr = (scan_idx << shift) + ADDR_W'(chan);
        stride     = ADDR_W'(sub) + ADDR_W'(1);
        next_addr  = cur_addr + (stride << shift);
    end
endmodule

// File: rtl/unl_fmt.sv
module unl_fmt
    import unl_pkg::*;
(
    input  logic [SAMP_W-1:0] word_in,
    output logic [OUT_W-1:0]  word_out
);
    generate
        if (OUT_W > SAMP_W) begin : g_ext
            assign word_out = {{(OUT_W-SAMP_W){word_in[SAMP_W-1]}}, word_in};
        end else begin : g_same
            assign word_out = word_in[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/unl_engine.sv
module unl_engine
    import unl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              req_valid,
    input  logic [4:0]        req_chan,
    input  logic [7:0]        req_offset,
    input  logic [1:0]        act_code,
    input  logic [ADDR_W-1:0] oldest_scan,
    input  logic              data_present,
    input  logic              rd_stb,
    input  logic [3:0]        rd_sub,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [11:0]       mem_rdata,
    output logic [15:0]       rd_data,
    output logic              q
);
    typedef struct packed {
        logic              unload;
        logic [ADDR_W-1:0] addr;
        logic              pend1;
        logic              pend2;
        logic [SAMP_W-1:0] held;
        logic [OUT_W-1:0]  rd;
        logic              q;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              chan_ok;
    logic [OUT_W-1:0]  held_ext;
    logic              in_unload;

    unl_addr #(.ADDR_W(ADDR_W)) u_addr (
        .act_code   (act_code),
        .chan       (req_chan),
        .offset     (req_offset),
        .oldest     (oldest_scan),
        .cur_addr   (st_q.addr),
        .sub        (rd_sub),
        .start_addr (start_addr),
        .next_addr  (next_addr),
        .chan_ok    (chan_ok)
    );

    unl_fmt u_fmt (
        .word_in  (st_q.held),
        .word_out (held_ext)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pend1 = 1'b0;
        st_d.pend2 = st_q.pend1;
        if (st_q.pend2) begin
            st_d.held = mem_rdata;
        end
        if (arm) begin
            st_d.unload = 1'b0;
            if (rd_stb) begin
                st_d.rd = '0;
                st_d.q  = 1'b0;
            end
        end else if (req_valid) begin
            st_d.unload = chan_ok && data_present;
            st_d.q      = chan_ok && data_present;
            if (chan_ok && data_present) begin
                st_d.addr  = start_addr;
                st_d.pend1 = 1'b1;
            end
        end else if (rd_stb) begin
            if (st_q.unload) begin
                st_d.rd    = held_ext;
                st_d.q     = 1'b1;
                st_d.addr  = next_addr;
                st_d.pend1 = 1'b1;
            end else begin
                st_d.rd = '0;
                st_d.q  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.addr;
    assign rd_data   = st_q.rd;
    assign q         = st_q.q;
    assign in_unload = st_q.unload;
endmodule

// File: rtl/unl_engine_chk.sv
module unl_engine_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              req_valid,
    input logic [4:0]        req_chan,
    input logic [7:0]        req_offset,
    input logic [1:0]        act_code,
    input logic [ADDR_W-1:0] oldest_scan,
    input logic              data_present,
    input logic              rd_stb,
    input logic [3:0]        rd_sub,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       rd_data,
    input logic              q,
    input logic              in_unload
);
    function automatic logic [ADDR_W-1:0] step_of(input logic [1:0] c, input logic [3:0] s);
        return ADDR_W'((32'(s) + 32'd1) * (32'd4 << c));
    endfunction

    function automatic logic [ADDR_W-1:0] start_of(input logic [1:0] c, input logic [4:0] ch,
                                                   input logic [7:0] off, input logic [ADDR_W-1:0] old);
        return ADDR_W'((32'(old) + 32'(off)) * (32'd4 << c) + 32'(ch));
    endfunction

    p_idle_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !arm && !req_valid && !in_unload) |=>
            (!q && rd_data == 16'd0 && mem_addr == $past(mem_addr)));

    p_arm_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && rd_stb) |=> (!q && rd_data == 16'd0 && !in_unload));

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && req_valid && (32'(req_chan) >= (32'd4 << act_code) || !data_present)) |=>
            (!q && !in_unload));

    p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:12] == {4{rd_data[11]}});

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !arm && !req_valid && in_unload) |=>
            (q && mem_addr == $past(mem_addr) + step_of($past(act_code), $past(rd_sub))));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && req_valid && data_present && 32'(req_chan) < (32'd4 << act_code)) |=>
            (q && in_unload &&
             mem_addr == start_of($past(act_code), $past(req_chan), $past(req_offset), $past(oldest_scan))));
endmodule

bind unl_engine unl_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .req_valid    (req_valid),
    .req_chan     (req_chan),
    .req_offset   (req_offset),
    .act_code     (act_code),
    .oldest_scan  (oldest_scan),
    .data_present (data_present),
    .rd_stb       (rd_stb),
    .rd_sub       (rd_sub),
    .mem_addr     (mem_addr),
    .rd_data      (rd_data),
    .q            (q),
    .in_unload    (in_unload)
);

// File: tb/tb_unl_engine.sv
module tb_unl_engine;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0;
    logic              req_valid = 1'b0;
    logic [4:0]        req_chan = '0;
    logic [7:0]        req_offset = '0;
    logic [1:0]        act_code = '0;
    logic [ADDR_W-1:0] oldest_scan = '0;
    logic              data_present = 1'b0;
    logic              rd_stb = 1'b0;
    logic [3:0]        rd_sub = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [11:0]       mem_rdata = '0;
    logic [15:0]       rd_data;
    logic              q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [ADDR_W-1:0] exp_addr;
    logic [15:0]       exp_rd;

    unl_engine #(.ADDR_W(ADDR_W)) dut (.*);

    always #5 clk = ~clk;

    function automatic logic [11:0] pat(input logic [ADDR_W-1:0] a);
        return 12'((32'(a) * 32'd37 + 32'd5) ^ (32'(a) >> 3));
    endfunction

    function automatic logic [15:0] sext(input logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    function automatic int n_of(input logic [1:0] c);
        return 4 << c;
    endfunction

    function automatic logic [ADDR_W-1:0] start_of(input logic [1:0] c, input logic [4:0] ch,
                                                   input logic [7:0] off, input logic [ADDR_W-1:0] old);
        return ADDR_W'((int'(old) + int'(off)) * n_of(c) + int'(ch));
    endfunction

    always_ff @(posedge clk) mem_rdata <= pat(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait2();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input logic [1:0] c, input logic [4:0] ch, input logic [7:0] off,
                          input logic [ADDR_W-1:0] old, input logic pres, output logic ok);
        act_code = c; req_chan = ch; req_offset = off; oldest_scan = old; data_present = pres;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ok = pres && (int'(ch) < n_of(c));
        if (ok) begin
            exp_addr = start_of(c, ch, off, old);
            check("R10 q on accept", 32'(q), 32'd1);
            check("R2 start address", 32'(mem_addr), 32'(exp_addr));
        end else begin
            check("R3 reject q", 32'(q), 32'd0);
        end
        wait2();
    endtask

    task automatic do_read(input logic [3:0] s, input logic active);
        rd_sub = s;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        if (active) begin
            exp_rd = sext(pat(exp_addr));
            check("R6 R5 read data", 32'(rd_data), 32'(exp_rd));
            check("R6 read q", 32'(q), 32'd1);
            exp_addr = ADDR_W'(int'(exp_addr) + (int'(s) + 1) * n_of(act_code));
            check("R7 stride step", 32'(mem_addr), 32'(exp_addr));
        end else begin
            exp_rd = 16'd0;
            check("R4 idle read data", 32'(rd_data), 32'd0);
            check("R4 idle read q", 32'(q), 32'd0);
        end
        wait2();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ok;
        logic [ADDR_W-1:0] a0;
        void'($urandom(32'd2024));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rd_data", 32'(rd_data), 32'd0);
        check("R1 reset q", 32'(q), 32'd0);
        check("R1 reset mem_addr", 32'(mem_addr), 32'd0);

        // R4: read outside unload, address unchanged
        a0 = mem_addr;
        do_read(4'd3, 1'b0);
        check("R4 address held", 32'(mem_addr), 32'(a0));

        // R2 R7: wrap around the top of memory, stride 16
        do_req(2'd3, 5'd31, 8'd255, 12'd4000, 1'b1, ok);
        do_read(4'd15, 1'b1);
        do_read(4'd0, 1'b1);

        // R3: channel beyond active count, and no recorded data
        do_req(2'd0, 5'd4, 8'd0, 12'd0, 1'b1, ok);
        do_read(4'd0, 1'b0);
        do_req(2'd2, 5'd1, 8'd0, 12'd0, 1'b0, ok);
        do_read(4'd0, 1'b0);

        // R8: arm ends unload mode
        do_req(2'd1, 5'd7, 8'd2, 12'd10, 1'b1, ok);
        do_read(4'd1, 1'b1);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        wait2();
        do_read(4'd1, 1'b0);

        // R9: arm and read in the same cycle
        do_req(2'd0, 5'd2, 8'd1, 12'd100, 1'b1, ok);
        do_read(4'd0, 1'b1);
        arm = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        arm = 1'b0; rd_stb = 1'b0;
        check("R9 arm+read data", 32'(rd_data), 32'd0);
        check("R9 arm+read q", 32'(q), 32'd0);
        wait2();
        do_read(4'd0, 1'b0);

        // R9: request and read in the same cycle, request wins
        do_req(2'd1, 5'd3, 8'd5, 12'd20, 1'b1, ok);
        do_read(4'd2, 1'b1);
        act_code = 2'd2; req_chan = 5'd9; req_offset = 8'd7; oldest_scan = 12'd300;
        data_present = 1'b1; req_valid = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rd_stb = 1'b0;
        exp_addr = start_of(2'd2, 5'd9, 8'd7, 12'd300);
        check("R9 req+read q", 32'(q), 32'd1);
        check("R9 req+read address", 32'(mem_addr), 32'(exp_addr));
        check("R9 req+read rd_data held", 32'(rd_data), 32'(exp_rd));
        wait2();
        do_read(4'd4, 1'b1);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [1:0] c;
            logic [4:0] ch;
            c  = 2'($urandom % 4);
            ch = 5'($urandom % 32);
            if ($urandom % 2 == 0) ch = 5'($urandom % n_of(c));
            do_req(c, ch, 8'($urandom), ADDR_W'($urandom), ($urandom % 8) != 0, ok);
            for (int k = 0; k < 1 + int'($urandom % 5); k++) begin
                do_read(4'($urandom), ok);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule